// File: doc/BRIEF.md
# Dual-Priority Interrupt Aggregator

The aggregator gathers up to 32 interrupt lines from peripherals and turns them into two request lines for a processor core. Each line has a priority bit and an enable bit. A rising edge on an enabled line sets a pending bit. The pending bit goes into the high bank when the line's priority bit is 1 and into the low bank when it is 0. Each bank is OR-reduced into its own registered core request.

Software uses a small synchronous register port to set up the priority and enable masks, read back all four registers, and clear pending bits by writing 1 to them.

A build-time parameter selects a reduced variant with no priority choice. It is meant for a group of 12 lines: every pending bit goes into the low bank, which drives the single request `irq_lo_o`.

Top module: `irq_aggregator`

Register map (`reg_addr`): 0 = priority mask (1 = high bank), 1 = enable mask, 2 = high pending bank, 3 = low pending bank. Bit i of every register belongs to source i. Writing 1 to a bit at address 2 or 3 clears that pending bit; writing 0 has no effect.

## Requirements
- R1: Each source has its own priority bit (address 0) and enable bit (address 1). Both are written from `reg_wdata` and read back unchanged.
- R2: A rising edge on an enabled source whose priority bit is 1 sets only that source's bit at address 2. The bit is visible on the clock edge that samples the rise.
- R3: A rising edge on an enabled source whose priority bit is 0 sets only that source's bit at address 3.
- R4: `irq_hi_o` is 1 exactly when the high bank is non-zero. It changes on the same clock edge as the bank.
- R5: `irq_lo_o` is 1 exactly when the low bank is non-zero. It changes on the same clock edge as the bank.
- R6: After reset, all priority bits are 0 (low), all enables are 0, both banks are clear and both requests are 0.
- R7: With `DUAL_PRIO=0` there is no priority choice. Writes to address 0 are ignored and it reads 0. Every enabled edge sets address 3, address 2 stays 0, and `irq_hi_o` stays 0.
- R8: Only a 0-to-1 transition sets a bit. A source held high does not set its bit again after it is cleared.
- R9: A source whose enable bit is 0 never sets a bit in either bank.
- R10: Writing 1 to a pending bit at address 2 or 3 clears it. Writing 0 leaves the bit unchanged.
- R11: Changing a source's priority bit while it is pending leaves the pending bit in its current bank until it is cleared.
- R12: If a rising edge and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R13: `reg_rdata` shows the register selected by `reg_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt source lines |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_hi_o | output | 1 | High-priority core request |
| irq_lo_o | output | 1 | Low-priority core request |

## Verification
A source rise that is driven between edges shows up in the pending bank and in the matching request on the very next rising edge. The bench therefore checks both request outputs at the falling edge that follows.

Register reads take one more edge: the address is set at a falling edge and the data is sampled at the next falling edge. A write likewise takes effect on the edge on which `reg_we` is seen.

For the case where a source rises on the same edge as a clear of that bit, the rise and the clear are driven together before a single edge, and the bank is read back afterwards.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_PRIO = 2'd0,
    A_EN   = 2'd1,
    A_HI   = 2'd2,
    A_LO   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_i;
  end

  assign rise_o = src_i & ~src_q;
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o,
  output logic         req_o
);
  logic [N-1:0] lat_q, lat_d;
  logic         req_q;

  // a new edge wins over a clear of the same bit
  assign lat_d = (lat_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q <= '0;
      req_q <= 1'b0;
    end else begin
      lat_q <= lat_d;
      req_q <= |lat_d;
    end
  end

  assign lat_o = lat_q;
  assign req_o = req_q;

  // R12: collision keeps the bit
  assert_set_beats_clear_R12: assert property (@(posedge clk) disable iff (rst)
    |(set_i & clr_i) |=> ((lat_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  // R10: a clear with no competing edge empties the bit
  assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (rst)
    |(clr_i & ~set_i & lat_q) |=> ((lat_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int N         = 32,
  parameter bit DUAL_PRIO = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [N-1:0]     prio_o,
  output logic [N-1:0]     en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)                        en_q <= '0;
    else if (we_i && addr_i == A_EN) en_q <= wdata_i[N-1:0];
  end
  assign en_o = en_q;

  generate
    if (DUAL_PRIO) begin : g_prio
      logic [N-1:0] prio_q;
      always_ff @(posedge clk) begin
        if (rst)                          prio_q <= '0;
        else if (we_i && addr_i == A_PRIO) prio_q <= wdata_i[N-1:0];
      end
      assign prio_o = prio_q;
    end else begin : g_noprio
      assign prio_o = '0;
    end
  endgenerate

  // R6: configuration comes out of reset as low priority, disabled
  assert_reset_cfg_R6: assert property (@(posedge clk)
    rst |=> (prio_o == '0 && en_o == '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NSRC      = 32,
  parameter bit DUAL_PRIO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_hi_o,
  output logic              irq_lo_o
);
  logic [NSRC-1:0] rise, prio, en;
  logic [NSRC-1:0] set_hi, set_lo, clr_hi, clr_lo;
  logic [NSRC-1:0] lat_hi, lat_lo;
  logic [REG_W-1:0] rd_d, rd_q;

  irq_edge_detect #(.N(NSRC)) u_edge (
    .clk(clk), .rst(rst), .src_i(src_i), .rise_o(rise)
  );

  irq_cfg_regs #(.N(NSRC), .DUAL_PRIO(DUAL_PRIO)) u_cfg (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .prio_o(prio), .en_o(en)
  );

  // steering of enabled edges into the two banks
  assign set_hi = rise & en & prio;
  assign set_lo = rise & en & ~prio;
  assign clr_hi = (reg_we && reg_addr == A_HI) ? reg_wdata[NSRC-1:0] : '0;
  assign clr_lo = (reg_we && reg_addr == A_LO) ? reg_wdata[NSRC-1:0] : '0;

  irq_latch_bank #(.N(NSRC)) u_lo (
    .clk(clk), .rst(rst), .set_i(set_lo), .clr_i(clr_lo),
    .lat_o(lat_lo), .req_o(irq_lo_o)
  );

  generate
    if (DUAL_PRIO) begin : g_hi
      irq_latch_bank #(.N(NSRC)) u_hi (
        .clk(clk), .rst(rst), .set_i(set_hi), .clr_i(clr_hi),
        .lat_o(lat_hi), .req_o(irq_hi_o)
      );
    end else begin : g_nohi
      assign lat_hi   = '0;
      assign irq_hi_o = 1'b0;
    end
  endgenerate

  // registered readback
  always_comb begin
    rd_d = '0;
    case (reg_addr)
      A_PRIO:  rd_d[NSRC-1:0] = prio;
      A_EN:    rd_d[NSRC-1:0] = en;
      A_HI:    rd_d[NSRC-1:0] = lat_hi;
      default: rd_d[NSRC-1:0] = lat_lo;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end
  assign reg_rdata = rd_q;

  // R2: newly pending high bits came from high-priority sources
  assert_hi_only_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lat_hi & ~$past(lat_hi) & ~$past(prio)) == '0));

  // R3: newly pending low bits came from low-priority sources
  assert_lo_only_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((lat_lo & ~$past(lat_lo) & $past(prio)) == '0));

  // R9: nothing becomes pending without its enable
  assert_en_gate_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((lat_hi | lat_lo) & ~$past(lat_hi | lat_lo) & ~$past(en)) == '0));

  // R4 / R5: requests track their banks
  assert_irq_hi_R4: assert property (@(posedge clk) disable iff (rst)
    irq_hi_o == (|lat_hi));
  assert_irq_lo_R5: assert property (@(posedge clk) disable iff (rst)
    irq_lo_o == (|lat_lo));
endmodule

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;
  localparam int NV = 6;
  localparam int NR = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_hi, irq_lo;

  logic [NR-1:0] src_r = '0;
  logic [1:0]    addr_r = '0;
  logic          we_r = 1'b0;
  logic [31:0]   wdata_r = '0;
  logic [31:0]   rdata_r;
  logic          irq_hi_r, irq_lo_r;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NSRC(32), .DUAL_PRIO(1'b1)) uut (
    .clk(clk), .rst(rst), .src_i(src), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  irq_aggregator #(.NSRC(NR), .DUAL_PRIO(1'b0)) uut_red (
    .clk(clk), .rst(rst), .src_i(src_r), .reg_addr(addr_r), .reg_we(we_r),
    .reg_wdata(wdata_r), .reg_rdata(rdata_r), .irq_hi_o(irq_hi_r), .irq_lo_o(irq_lo_r)
  );

  // columns: priority, enable, source pulse, expected high bank, expected low bank
  localparam logic [31:0] VEC [NV][5] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0000, 32'h0000_00FF},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001, 32'h8000_0001, 32'h0000_0000},
    '{32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 32'h0F0F_0F0F},
    '{32'hAAAA_AAAA, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_AAAA, 32'h0000_5555},
    '{32'h1234_5678, 32'hFFFF_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    '{32'h0000_FFFF, 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h0000_000F, 32'h000F_0000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  task automatic wr_r(input logic [1:0] a, input logic [31:0] d);
    addr_r = a; wdata_r = d; we_r = 1'b1;
    tick();
    we_r = 1'b0;
  endtask

  task automatic rd_r(input logic [1:0] a, output logic [31:0] d);
    addr_r = a;
    tick();
    d = rdata_r;
  endtask

  task automatic pulse(input logic [31:0] p);
    src = p;
    tick();
    src = '0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;

    // R6: reset state
    check("R6 irq_hi", {31'd0, irq_hi}, 32'd0);
    check("R6 irq_lo", {31'd0, irq_lo}, 32'd0);
    rd(2'd0, v); check("R6 prio", v, 32'd0);
    rd(2'd1, v); check("R6 en", v, 32'd0);
    rd(2'd2, v); check("R6 hi bank", v, 32'd0);
    rd(2'd3, v); check("R6 lo bank", v, 32'd0);

    // table of steering vectors: R1 R2 R3 R4 R5 R9 R13
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][0]);
      wr(2'd1, VEC[i][1]);
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd3, 32'hFFFF_FFFF);
      rd(2'd0, v); check("R1 prio readback", v, VEC[i][0]);
      rd(2'd1, v); check("R1 en readback", v, VEC[i][1]);
      pulse(VEC[i][2]);
      check("R4 irq_hi", {31'd0, irq_hi}, {31'd0, VEC[i][3] != 0});
      check("R5 irq_lo", {31'd0, irq_lo}, {31'd0, VEC[i][4] != 0});
      rd(2'd2, v); check("R2/R9 hi bank", v, VEC[i][3]);
      rd(2'd3, v); check("R3/R9 lo bank", v, VEC[i][4]);
    end

    // clean slate for the directed cases
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h0000_000F);
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);

    // R8: level held high does not re-latch after clear
    src = 32'h1;
    tick();
    rd(2'd3, v); check("R8 first edge", v, 32'h1);
    wr(2'd3, 32'h1);
    tick(); tick();
    rd(2'd3, v); check("R8 held level no relatch", v, 32'h0);
    check("R8 irq_lo quiet", {31'd0, irq_lo}, 32'd0);
    src = '0;
    tick();

    // R10: write 0 keeps, write 1 clears
    pulse(32'h4);
    wr(2'd3, 32'h0);
    rd(2'd3, v); check("R10 write zero keeps", v, 32'h4);
    wr(2'd3, 32'h4);
    rd(2'd3, v); check("R10 write one clears", v, 32'h0);

    // R12: edge and clear on the same edge
    pulse(32'h4);
    tick();
    src = 32'h4; addr = 2'd3; wdata = 32'h4; we = 1'b1;
    tick();
    we = 1'b0; src = '0;
    rd(2'd3, v); check("R12 collision keeps bit", v, 32'h4);
    wr(2'd3, 32'h4);

    // R11: priority change while pending
    pulse(32'h2);
    wr(2'd0, 32'h2);
    rd(2'd3, v); check("R11 stays in low bank", v, 32'h2);
    rd(2'd2, v); check("R11 high bank empty", v, 32'h0);
    wr(2'd3, 32'h2);
    pulse(32'h2);
    rd(2'd2, v); check("R11 next edge goes high", v, 32'h2);
    check("R11 irq_hi", {31'd0, irq_hi}, 32'd1);

    // R7: reduced variant
    wr_r(2'd0, 32'h0000_0FFF);
    wr_r(2'd1, 32'h0000_0FFF);
    rd_r(2'd0, v); check("R7 prio reads zero", v, 32'h0);
    src_r = 12'h801;
    tick();
    src_r = '0;
    check("R7 irq_lo", {31'd0, irq_lo_r}, 32'd1);
    check("R7 irq_hi stays low", {31'd0, irq_hi_r}, 32'd0);
    rd_r(2'd3, v); check("R7 single bank", v, 32'h801);
    rd_r(2'd2, v); check("R7 high bank absent", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule